// File: doc/BRIEF.md
# Programmable Period Timer with Sign-Bit Terminal Detect

This block produces a one-cycle pulse every N enabled clock cycles, where N is held in a period register that can be written at run time. It does not compare the running count against the stored period on every cycle. On each reload the counter takes a value derived from the period. It then counts down. The terminal cycle is found from one extra top bit alone: the counter is one bit wider than the period field, and it sets that top bit when it wraps below zero.

The loaded value is the effective period minus two, which is one less than a plain down-counter to zero would start from. The wrap therefore lands on the cycle where such a counter would have reached zero. A period of 1 loads all ones, so the top bit is already set and the timer pulses on every enabled cycle. A new period written by software is used at the next reload. A restart input forces an immediate reload. No data streams through the block, so every pin is a plain control or status signal.

Top module: `ptmr_timer`

## Requirements
- R1: While `rst` is high, `tick` stays low and the period register takes `INIT_PERIOD`. With `enable` held high after reset is released, the first `tick` comes on the INIT_PERIOD-th cycle.
- R2: For a programmed period N with 1 <= N <= 2^PERIOD_W-1, `tick` rises once every N enabled cycles. Each pulse is exactly one cycle wide when N >= 2.
- R3: A programmed period of 0 acts as a period of 1, so `tick` is high on every enabled cycle.
- R4: While `enable` is low and `restart` is low, the count holds and `tick` stays low. When `enable` returns high, the period resumes with its remaining cycles.
- R5: A write (`period_wr` high, value on `period_din`) does not change the period already running. The new value sets the length of the period that begins at the next reload. A write made in the terminal cycle itself applies only to the period after the next one.
- R6: With `restart` high, `tick` is low in that cycle and the counter reloads from the period register as it stood before any write in the same cycle. The next `tick` then follows N enabled cycles after the restart cycle. This holds whatever the level of `enable`.
- R7: The all-ones period value 2^PERIOD_W-1 (255 by default) gives a full-length period of that many cycles, with no early terminal detect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| period_wr | input | 1 | Write strobe for the period register |
| period_din | input | PERIOD_W | New period value |
| enable | input | 1 | Count enable; low holds the count |
| restart | input | 1 | Force an immediate reload of the counter |
| tick | output | 1 | One-cycle terminal pulse |

## Verification
The embedded assertions check the following on every cycle:
- the count holds while the timer is idle;
- the period register holds when there is no write;
- a restart leaves the top bit clear whenever the period is 2 or more;
- a pulse is never followed directly by another one when the period is 2 or more.

Other behaviour shows only over whole periods, so only the bench's scenarios can demonstrate it. This covers the exact spacing between pulses, measured against an up-counting reference, and the remaining count after enable has been gated. It also covers the deferred effect of a write made mid-period and in the terminal cycle, and the extremes of the period field: 0, 1 and all ones.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  // What the down-counter does on the next edge.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_DEC  = 2'd1,
    ACT_LOAD = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/ptmr_period_reg.sv
module ptmr_period_reg #(
  parameter int PW          = 8,
  parameter int INIT_PERIOD = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] prd_q
);
  always_ff @(posedge clk) begin
    if (rst)     prd_q <= PW'(INIT_PERIOD);
    else if (wr) prd_q <= din;
  end

  // Without a write strobe the stored period must not move.
  assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(prd_q));
endmodule

// File: rtl/ptmr_load_calc.sv
module ptmr_load_calc #(
  parameter int PW = 8,
  localparam int CW = PW + 1
) (
  input  logic [PW-1:0] prd,
  output logic [CW-1:0] load_val
);
  logic [CW-1:0] eff;

  // A period of 0 is treated as 1; the load value is the effective
  // period minus two, so a period of 1 loads all ones (top bit set).
  always_comb begin
    eff      = (prd == '0) ? CW'(1) : {1'b0, prd};
    load_val = eff - CW'(2);
  end
endmodule

// File: rtl/ptmr_downcount.sv
module ptmr_downcount
  import ptmr_pkg::*;
#(
  parameter int PW = 8,
  localparam int CW = PW + 1,
  parameter logic [CW-1:0] RST_LOAD = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  cnt_act_e      act,
  input  logic [CW-1:0] load_val,
  output logic          term
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RST_LOAD;
    end else begin
      unique case (act)
        ACT_LOAD: cnt_q <= load_val;
        ACT_DEC:  cnt_q <= cnt_q - CW'(1);
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  // Terminal detect is the top bit alone.
  assign term = cnt_q[CW-1];

  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD) |=> $stable(cnt_q));

  assert_reload_clears_top_R6: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_LOAD) && !load_val[CW-1] |=> !term);

  assert_no_early_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_DEC) && (cnt_q != '0) |=> !term);
endmodule

// File: rtl/ptmr_timer.sv
module ptmr_timer
  import ptmr_pkg::*;
#(
  parameter int PERIOD_W    = 8,
  parameter int INIT_PERIOD = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                period_wr,
  input  logic [PERIOD_W-1:0] period_din,
  input  logic                enable,
  input  logic                restart,
  output logic                tick
);
  localparam int CW = PERIOD_W + 1;
  localparam logic [CW-1:0] RST_LOAD =
    (INIT_PERIOD <= 1) ? {CW{1'b1}} : CW'(INIT_PERIOD) - CW'(2);

  logic [PERIOD_W-1:0] prd_q;
  logic [CW-1:0]       load_val;
  logic                term;
  cnt_act_e            act;

  ptmr_period_reg #(.PW(PERIOD_W), .INIT_PERIOD(INIT_PERIOD)) u_preg (
    .clk(clk), .rst(rst), .wr(period_wr), .din(period_din), .prd_q(prd_q)
  );

  ptmr_load_calc #(.PW(PERIOD_W)) u_load (
    .prd(prd_q), .load_val(load_val)
  );

  ptmr_downcount #(.PW(PERIOD_W), .RST_LOAD(RST_LOAD)) u_cnt (
    .clk(clk), .rst(rst), .act(act), .load_val(load_val), .term(term)
  );

  // Restart wins; otherwise enable gates counting; terminal reloads.
  always_comb begin
    if (restart)      act = ACT_LOAD;
    else if (!enable) act = ACT_HOLD;
    else if (term)    act = ACT_LOAD;
    else              act = ACT_DEC;
  end

  assign tick = !rst && enable && !restart && term;

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    tick && (prd_q > PERIOD_W'(1)) |=> !tick);
endmodule

// File: tb/ptmr_timer_tb_top.sv
module ptmr_timer_tb_top;
  localparam int PW   = 8;
  localparam int INIT = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1, period_wr = 1'b0, enable = 1'b0, restart = 1'b0;
  logic [PW-1:0] period_din = '0;
  logic          tick;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  ptmr_timer #(.PERIOD_W(PW), .INIT_PERIOD(INIT)) dut_i (
    .clk(clk), .rst(rst), .period_wr(period_wr), .period_din(period_din),
    .enable(enable), .restart(restart), .tick(tick)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: sample tick mid-cycle, then move just past the next edge.
  task automatic step(output logic t);
    @(negedge clk);
    t = tick;
    @(posedge clk);
    #1;
  endtask

  // Reference up-counter: cycles up to and including the next tick.
  task automatic wait_tick(output int n);
    logic t;
    n = 0;
    do begin
      step(t);
      n++;
    end while (!t && n < 2000);
  endtask

  task automatic program_period(int v);
    logic t;
    period_din = PW'(v); period_wr = 1'b1; step(t); period_wr = 1'b0;
    restart = 1'b1; step(t); restart = 1'b0;
  endtask

  task automatic t_reset;
    logic t;
    int n;
    enable = 1'b1; rst = 1'b1;
    for (int i = 0; i < 4; i++) begin step(t); check("R1 tick in reset", int'(t), 0); end
    rst = 1'b0;
    wait_tick(n);
    check("R1 first period", n, INIT);
  endtask

  task automatic measure(string req, int v, int exp, int reps);
    int n;
    program_period(v);
    for (int i = 0; i < reps; i++) begin wait_tick(n); check(req, n, exp); end
  endtask

  task automatic t_hold;
    logic t;
    int n, seen;
    program_period(6);
    wait_tick(n); check("R4 base period", n, 6);
    step(t); step(t);
    enable = 1'b0; seen = 0;
    for (int i = 0; i < 10; i++) begin step(t); seen += int'(t); end
    check("R4 no tick while disabled", seen, 0);
    enable = 1'b1;
    wait_tick(n); check("R4 remaining cycles", n, 4);
  endtask

  task automatic t_write;
    logic t;
    int n;
    program_period(10);
    wait_tick(n); check("R5 base period", n, 10);
    step(t); step(t); step(t);
    period_din = 8'd4; period_wr = 1'b1; step(t); period_wr = 1'b0;
    wait_tick(n); check("R5 running period kept", n, 6);
    wait_tick(n); check("R5 new period", n, 4);
    step(t); step(t); step(t);
    period_din = 8'd3; period_wr = 1'b1; step(t); period_wr = 1'b0;
    check("R5 write in terminal cycle", int'(t), 1);
    wait_tick(n); check("R5 old value for next period", n, 4);
    wait_tick(n); check("R5 value after that", n, 3);
  endtask

  task automatic t_restart;
    logic t;
    int n;
    program_period(9);
    wait_tick(n); check("R6 base period", n, 9);
    step(t); step(t); step(t); step(t);
    restart = 1'b1; step(t); restart = 1'b0;
    check("R6 no tick in restart cycle", int'(t), 0);
    wait_tick(n); check("R6 full period after restart", n, 9);
    enable = 1'b0; restart = 1'b1; step(t); restart = 1'b0;
    step(t); step(t); step(t);
    enable = 1'b1;
    wait_tick(n); check("R6 restart while disabled", n, 9);
  endtask

  initial begin
    @(posedge clk); #1;
    t_reset();
    measure("R2 period 3", 3, 3, 3);
    measure("R2 period 2", 2, 2, 3);
    measure("R2 period 7", 7, 7, 2);
    measure("R2 period 1", 1, 1, 4);
    measure("R3 period 0", 0, 1, 4);
    measure("R7 all-ones period", 255, 255, 2);
    t_hold();
    t_write();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule